// File: doc/BRIEF.md
# Conditional Jump Decision and Target Unit

This block evaluates a single jump-format instruction word. It takes the word, the address where that word sits, and the four status flags (negative, zero, carry, overflow). It decides whether the jump is taken and produces the next program counter. The word is a jump when its top three bits are `001`. A three-bit condition field then selects one of eight fixed tests on the flags. These include two signed comparisons that weigh the negative flag against the overflow flag. A ten-bit two's-complement offset counts words from the word after the jump.

When the jump is taken, the next program counter is the following address plus twice the sign-extended offset. Otherwise it is the following address. Words outside the jump format raise a separate flag and are never taken. The flags travel alongside the result unchanged, because a jump does not alter them. The default build registers every result behind a one-cycle valid pipeline stage. A parameter removes that stage and gives a purely combinational path.

Top module: `jump_target_unit`

## Requirements
- R1: With `instr[15:13]` = `001`, condition field `instr[12:10]` = `000` is taken exactly when Z = 0, and `001` is taken exactly when Z = 1. The flags are packed as `flags_in[3]` = N, `[2]` = Z, `[1]` = C, `[0]` = V.
- R2: Condition `010` is taken exactly when C = 0, `011` exactly when C = 1, and `100` exactly when N = 1.
- R3: Condition `101` is taken when N equals V, `110` is taken when N differs from V, and `111` is taken for every flag value.
- R4: A taken jump gives `next_pc` = address + 2 + 2 × sign-extended `instr[9:0]`, computed modulo 2^16. The offset range is −512 to +511 words.
- R5: A jump whose condition is false gives `next_pc` = address + 2, computed modulo 2^16.
- R6: A word with `instr[15:13]` other than `001` gives `not_jump` = 1 and `taken` = 0, and `next_pc` = address + 2. A jump word gives `not_jump` = 0.
- R7: `flags_out` equals the `flags_in` that entered with the same word.
- R8: Bit 0 of `next_pc` is always 0. Bit 0 of `instr_addr` is ignored.
- R9: In the registered build, `out_valid` rises one cycle after each cycle with `in_valid` high and stays low otherwise. Reset clears `out_valid`, `taken`, `not_jump`, `next_pc` and `flags_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word, address and flags are presented this cycle |
| instr | input | 16 | Instruction word to evaluate |
| instr_addr | input | AW | Address of the instruction word |
| flags_in | input | 4 | Status flags {N, Z, C, V} |
| out_valid | output | 1 | Result outputs hold a new result |
| taken | output | 1 | The jump is taken |
| not_jump | output | 1 | The word is not in jump format |
| next_pc | output | AW | Address of the next instruction |
| flags_out | output | 4 | Flags passed through unchanged |

## Verification
Every condition code is driven with all sixteen flag combinations. This separates each code's test from its neighbours, and the N-versus-V pair from the plain N test. The carry-set, not-equal and unconditional check words are placed at their known addresses. Offsets at both extremes and an address near the top of memory expose faults in sign extension, scaling and wrap-around. Non-jump words and an odd address show that decoding rejects foreign formats and that address bit 0 plays no part.

// File: rtl/jump_target_unit.sv
module jump_target_unit #(
  parameter int AW   = 16,
  parameter int OFFW = 10,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   instr,
  input  logic [AW-1:0] instr_addr,
  input  logic [3:0]    flags_in,
  output logic          out_valid,
  output logic          taken,
  output logic          not_jump,
  output logic [AW-1:0] next_pc,
  output logic [3:0]    flags_out
);

  localparam int EXT = AW - OFFW - 1;
  localparam logic [AW-1:0] STEP = AW'(2);

  logic          is_jmp, cond_ok, c_taken;
  logic [AW-1:0] base, seq_pc, off_bytes, tgt_pc, c_npc;
  logic          fn, fz, fc, fv;

  assign {fn, fz, fc, fv} = flags_in;
  assign is_jmp    = (instr[15:13] == 3'b001);
  assign base      = {instr_addr[AW-1:1], 1'b0};
  assign seq_pc    = base + STEP;
  assign off_bytes = {{EXT{instr[OFFW-1]}}, instr[OFFW-1:0], 1'b0};
  assign tgt_pc    = seq_pc + off_bytes;

  always_comb begin
    case (instr[12:10])
      3'd0:    cond_ok = ~fz;
      3'd1:    cond_ok = fz;
      3'd2:    cond_ok = ~fc;
      3'd3:    cond_ok = fc;
      3'd4:    cond_ok = fn;
      3'd5:    cond_ok = (fn == fv);
      3'd6:    cond_ok = (fn != fv);
      default: cond_ok = 1'b1;
    endcase
  end

  assign c_taken = is_jmp & cond_ok;
  assign c_npc   = c_taken ? tgt_pc : seq_pc;

  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          taken     <= 1'b0;
          not_jump  <= 1'b0;
          next_pc   <= '0;
          flags_out <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            taken     <= c_taken;
            not_jump  <= ~is_jmp;
            next_pc   <= c_npc;
            flags_out <= flags_in;
          end
        end
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
      AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> flags_out == $past(flags_in)); // R7
      AST_FOREIGN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && not_jump |-> !taken); // R6
      AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> next_pc[0] == 1'b0); // R8
      AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !not_jump && $past(instr[12:10]) == 3'b111 |-> taken); // R3
      AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !taken |-> next_pc == {$past(instr_addr[AW-1:1]), 1'b0} + STEP); // R5
    end else begin : g_comb
      assign out_valid = in_valid;
      assign taken     = c_taken;
      assign not_jump  = ~is_jmp;
      assign next_pc   = c_npc;
      assign flags_out = flags_in;
    end
  endgenerate

endmodule

// File: tb/jump_target_unit_tb.sv
module jump_target_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] instr_addr = '0;
  logic [3:0]  flags_in = '0;
  logic        out_valid, taken, not_jump;
  logic [15:0] next_pc;
  logic [3:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        q_taken[$];
  logic        q_nj[$];
  logic [15:0] q_pc[$];
  logic [3:0]  q_flags[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  jump_target_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .instr_addr(instr_addr), .flags_in(flags_in), .out_valid(out_valid),
    .taken(taken), .not_jump(not_jump), .next_pc(next_pc), .flags_out(flags_out)
  );

  function automatic logic model_cond(input logic [2:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    unique case (cc)
      3'b000: return z == 1'b0;
      3'b001: return z == 1'b1;
      3'b010: return c == 1'b0;
      3'b011: return c == 1'b1;
      3'b100: return n == 1'b1;
      3'b101: return n == v;
      3'b110: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send(input logic [15:0] w, input logic [15:0] a, input logic [3:0] f,
                      input string tag);
    logic        jmp, tk;
    int          off;
    logic [15:0] nxt, pc;
    jmp = (w[15:13] == 3'b001);
    tk  = jmp && model_cond(w[12:10], f);
    off = w[9] ? int'(w[9:0]) - 1024 : int'(w[9:0]);
    nxt = (a & 16'hFFFE) + 16'd2;
    pc  = tk ? nxt + 16'(off * 2) : nxt;
    q_taken.push_back(tk);
    q_nj.push_back(!jmp);
    q_pc.push_back(pc);
    q_flags.push_back(f);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid   = 1'b1;
    instr      = w;
    instr_addr = a;
    flags_in   = f;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_pc.size() == 0) begin
        check(1'b0, "R9", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        logic        et, en;
        logic [15:0] ep;
        logic [3:0]  ef;
        string       tg;
        et = q_taken.pop_front();
        en = q_nj.pop_front();
        ep = q_pc.pop_front();
        ef = q_flags.pop_front();
        tg = q_tag.pop_front();
        check(taken == et, tg, "taken", 32'(taken), 32'(et));
        check(not_jump == en, tg, "not_jump", 32'(not_jump), 32'(en));
        check(next_pc == ep, tg, "next_pc", 32'(next_pc), 32'(ep));
        check(flags_out == ef, "R7", "flags_out", 32'(flags_out), 32'(ef));
        check(next_pc[0] == 1'b0, "R8", "next_pc bit0", 32'(next_pc[0]), 32'd0);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && taken == 1'b0 && not_jump == 1'b0 &&
          next_pc == 16'h0 && flags_out == 4'h0, "R9", "reset state",
          {out_valid, taken, not_jump, next_pc, flags_out}, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R3: every code against every flag pattern
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        string t;
        t = (cc < 2) ? "R1" : (cc < 5) ? "R2" : "R3";
        send({3'b001, 3'(cc), 10'h005}, 16'h4000 + 16'(cc * 32), 4'(f), t);
      end
    end
    // known words: carry-set -28, not-equal, unconditional (R4 R5)
    send(16'h2FE4, 16'h8100, 4'b0010, "R4");
    send(16'h2FE4, 16'h8100, 4'b0000, "R5");
    send(16'h23FD, 16'h8026, 4'b0000, "R4");
    send(16'h23FD, 16'h8026, 4'b0100, "R5");
    send(16'h3FF3, 16'h802A, 4'b1111, "R4");
    // offset extremes and wrap (R4)
    send(16'h3DFF, 16'h8000, 4'b0000, "R4");
    send(16'h3E00, 16'h8000, 4'b0000, "R4");
    send(16'h3C01, 16'hFFFE, 4'b0000, "R4");
    send(16'h3E00, 16'h0000, 4'b0000, "R4");
    // fallthrough wrap (R5)
    send(16'h2400, 16'hFFFE, 4'b0000, "R5");
    // foreign formats (R6)
    send(16'h4504, 16'h9000, 4'b1111, "R6");
    send(16'h1005, 16'h9002, 4'b0100, "R6");
    send(16'h5FFF, 16'h9004, 4'b0000, "R6");
    // odd address ignored (R8)
    send(16'h3C00, 16'h8027, 4'b0000, "R8");
    send(16'h3C03, 16'h1001, 4'b0000, "R8");
    idle();
    // gap: out_valid must stay low (R9)
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9", "idle out_valid", 32'(out_valid), 32'd0);
    check(q_pc.size() == 0, "R9", "pending results", 32'(q_pc.size()), 32'd0);
    // spaced single item then idle (R9)
    send(16'h3C00, 16'h2000, 4'b0000, "R9");
    idle();
    repeat (3) @(negedge clk);
    check(q_pc.size() == 0 && out_valid == 1'b0, "R9", "single item drained",
          32'(q_pc.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule